// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block translates a virtual address into a physical address. It reads page-table entries from memory one level at a time, through a single read port. A request carries the virtual address and three access flags: write, user and execute. Mode inputs select the walk type: paging on or off, 32-bit or 64-bit entries (PAE), 4-level long mode, and write-protect enforcement. A root-table pointer gives the first table base.

The walker takes one request at a time over a valid/ready handshake. It stays busy until it has delivered a physical address or a fault flag. A walk can end in four ways:
- at the last level with a 4 KiB page;
- early on a large page: 2 MiB with 64-bit entries, or 4 MiB with 32-bit entries, where the base is extended to 40 bits from spare entry bits;
- at once when paging is off;
- on the first entry that is absent or that refuses the access.

Top module: `page_walker`

## Requirements
- R1: A successful 4 KiB walk makes exactly 2 memory reads with 32-bit entries, 3 with 64-bit entries outside long mode, and 4 in long mode.
- R2: At a level L (counted down to 1), the table index is (vaddr >> (s*(L-1)+12)) masked to s bits. Here s is 10 with 32-bit entries and 9 with 64-bit entries. The read address is the table base plus the index times 4 or 8. With 32-bit entries only bits 31:0 of the returned data are used.
- R3: The first table base comes from the root pointer. With 64-bit entries outside long mode it is the root with bits 4:0 cleared, used without further masking. In long mode it is root bits 51:12. With 32-bit entries it is root bits 31:12.
- R4: With paging off, the response is the virtual address zero-extended, with no fault and no memory read.
- R5: An entry whose bit 0 (present) is clear ends the walk with a fault.
- R6: A write access to an entry whose bit 1 (writable) is clear faults only while write-protect enforcement is on.
- R7: A user access to an entry whose bit 2 (user) is clear always faults.
- R8: An execute access to an entry whose bit 63 (no-execute) is set faults with 64-bit entries. With 32-bit entries no-execute is never checked.
- R9: With 64-bit entries outside long mode, the top-level entry is checked for presence only; its permission bits are ignored.
- R10: With 64-bit entries, a level-2 entry with bit 7 set ends the walk. The result is entry bits 51:21 joined with vaddr[20:0].
- R11: With 32-bit entries, a level-2 entry with bit 7 set ends the walk. The result is {entry[20:13], entry[31:22], vaddr[21:0]}, zero-extended.
- R12: A request is taken only while idle. Busy stays high until the response is consumed. The response and its data hold steady while not accepted.
- R13: A 4 KiB result is the last entry's bits 51:12 (64-bit entries) or 31:12 (32-bit entries) joined with vaddr[11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request taken |
| reqVaddr | input | VA_W | Virtual address |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user level |
| reqExec | input | 1 | Access is an instruction fetch |
| cfgPaging | input | 1 | Translation enabled |
| cfgPae | input | 1 | 64-bit entries |
| cfgLong | input | 1 | Four-level long mode |
| cfgWp | input | 1 | Enforce write protection |
| cfgRoot | input | PA_W | Root table pointer |
| memRdValid | output | 1 | Entry read requested |
| memRdAddr | output | PA_W | Entry byte address |
| memRdDone | input | 1 | Read data returned this cycle |
| memRdData | input | 64 | Returned entry |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspPaddr | output | PA_W | Physical address |
| rspFault | output | 1 | Translation faulted |
| busy | output | 1 | Walk in progress or response pending |

## Verification
The hardest cases to reach from the ports are the ones that hinge on which level an entry sits at. Examples are a top-level 64-bit entry whose permission bits must be ignored, and a bit-7 entry that ends the walk only at level 2. The bench reaches them with one fixed memory image built as a sparse lookup. The image holds separate table trees for each mode. Each virtual address is chosen so that its indices land on an entry with the exact bit pattern in question. Each vector also checks the count of reads and the first read address, so a wrong level count, index or root masking misses the image and shows up.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef struct packed {
    logic load;
    logic bypass;
    logic step;
    logic finish;
    logic fault;
  } pwStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_RESP} pwState_t;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_LARGE   = 7;
  localparam int BIT_NOEXEC  = 63;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cfgPaging,
  input  logic      memRdDone,
  input  logic      chkFault,
  input  logic      chkLast,
  input  logic      rspReady,
  output logic      reqReady,
  output logic      memRdValid,
  output logic      rspValid,
  output logic      busy,
  output pwStrobe_t strobe
);
  pwState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        if (!cfgPaging) begin
          strobe.bypass = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          stateNext = ST_READ;
        end
      end
      ST_READ: if (memRdDone) begin
        if (chkFault) begin
          strobe.fault = 1'b1;
          stateNext    = ST_RESP;
        end else if (chkLast) begin
          strobe.finish = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          strobe.step = 1'b1;
        end
      end
      ST_RESP: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_READ);
  assign rspValid   = (state == ST_RESP);
  assign busy       = (state != ST_IDLE);

  // R12: an unaccepted response stays offered
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R4: paging off goes straight to a response with no read
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !cfgPaging |=> rspValid && !memRdValid);
endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rstN,
  input  pwStrobe_t       strobe,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqWrite,
  input  logic            reqUser,
  input  logic            reqExec,
  input  logic            cfgPae,
  input  logic            cfgLong,
  input  logic            cfgWp,
  input  logic [PA_W-1:0] cfgRoot,
  input  logic [63:0]     memRdData,
  output logic [PA_W-1:0] memRdAddr,
  output logic            chkFault,
  output logic            chkLast,
  output logic [PA_W-1:0] rspPaddr,
  output logic            rspFault
);
  localparam int PSE_W = 40;

  logic [VA_W-1:0] va;
  logic            wr, usr, ex, pae, lng, wp;
  logic [2:0]      lvl;
  logic [PA_W-1:0] base;

  logic [2:0]      lvlM1;
  logic [5:0]      shAmt;
  logic [VA_W-1:0] shifted;
  logic [9:0]      idx;
  logic [12:0]     offset;
  logic [63:0]     ent;
  logic            isTopPae, isLarge, permFail;
  logic [PA_W-1:0] nextBase, leafPa, largePa, rootBase;

  // first table base, chosen by mode at acceptance
  always_comb begin
    if (!cfgPae)      rootBase = {{(PA_W-32){1'b0}}, cfgRoot[31:12], 12'h000};
    else if (cfgLong) rootBase = {cfgRoot[PA_W-1:12], 12'h000};
    else              rootBase = {cfgRoot[PA_W-1:5], 5'h00};
  end

  // index and entry address for the current level
  always_comb begin
    lvlM1   = lvl - 3'd1;
    shAmt   = 6'd12 + (pae ? 6'd9 : 6'd10) * {3'b000, lvlM1};
    shifted = va >> shAmt;
    idx     = pae ? {1'b0, shifted[8:0]} : shifted[9:0];
    offset  = pae ? {idx, 3'b000} : {1'b0, idx, 2'b00};
    memRdAddr = base + {{(PA_W-13){1'b0}}, offset};
  end

  // entry checks and candidate results
  always_comb begin
    ent      = pae ? memRdData : {32'h0, memRdData[31:0]};
    isTopPae = pae && !lng && (lvl == 3'd3);
    isLarge  = (lvl == 3'd2) && ent[BIT_LARGE];
    permFail = (wr && wp && !ent[BIT_WRITE]) ||
               (usr && !ent[BIT_USER]) ||
               (pae && ex && ent[BIT_NOEXEC]);
    chkFault = !ent[BIT_PRESENT] || (!isTopPae && permFail);
    chkLast  = (lvl == 3'd1) || (!isTopPae && isLarge);
    nextBase = pae ? {ent[PA_W-1:12], 12'h000}
                   : {{(PA_W-32){1'b0}}, ent[31:12], 12'h000};
    leafPa   = {nextBase[PA_W-1:12], va[11:0]};
    largePa  = pae ? {ent[PA_W-1:21], va[20:0]}
                   : {{(PA_W-PSE_W){1'b0}}, ent[20:13], ent[31:22], va[21:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      va <= '0; wr <= 1'b0; usr <= 1'b0; ex <= 1'b0;
      pae <= 1'b0; lng <= 1'b0; wp <= 1'b0;
      lvl <= 3'd1; base <= '0; rspPaddr <= '0; rspFault <= 1'b0;
    end else begin
      if (strobe.load) begin
        va  <= reqVaddr;  wr <= reqWrite; usr <= reqUser; ex <= reqExec;
        pae <= cfgPae;    lng <= cfgLong; wp <= cfgWp;
        lvl  <= !cfgPae ? 3'd2 : (cfgLong ? 3'd4 : 3'd3);
        base <= rootBase;
        rspFault <= 1'b0;
        if (strobe.bypass) rspPaddr <= {{(PA_W-VA_W){1'b0}}, reqVaddr};
      end
      if (strobe.step) begin
        base <= nextBase;
        lvl  <= lvl - 3'd1;
      end
      if (strobe.finish) begin
        rspPaddr <= isLarge ? largePa : leafPa;
        rspFault <= 1'b0;
      end
      if (strobe.fault) rspFault <= 1'b1;
    end
  end

  // R1: the level counter never leaves the 1..4 range
  assert_level_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lvl >= 3'd1) && (lvl <= 3'd4));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqWrite,
  input  logic            reqUser,
  input  logic            reqExec,
  input  logic            cfgPaging,
  input  logic            cfgPae,
  input  logic            cfgLong,
  input  logic            cfgWp,
  input  logic [PA_W-1:0] cfgRoot,
  output logic            memRdValid,
  output logic [PA_W-1:0] memRdAddr,
  input  logic            memRdDone,
  input  logic [63:0]     memRdData,
  output logic            rspValid,
  input  logic            rspReady,
  output logic [PA_W-1:0] rspPaddr,
  output logic            rspFault,
  output logic            busy
);
  pwStrobe_t strobe;
  logic      chkFault, chkLast;

  pw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgPaging(cfgPaging),
    .memRdDone(memRdDone), .chkFault(chkFault), .chkLast(chkLast),
    .rspReady(rspReady), .reqReady(reqReady), .memRdValid(memRdValid),
    .rspValid(rspValid), .busy(busy), .strobe(strobe)
  );

  pw_dpath #(.VA_W(VA_W), .PA_W(PA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .reqExec(reqExec),
    .cfgPae(cfgPae), .cfgLong(cfgLong), .cfgWp(cfgWp), .cfgRoot(cfgRoot),
    .memRdData(memRdData), .memRdAddr(memRdAddr), .chkFault(chkFault),
    .chkLast(chkLast), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  // R12: a held response keeps its data
  assert_rsp_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPaddr) && $stable(rspFault));

  // R5: an absent entry turns into a faulting response
  assert_not_present_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && memRdDone && !memRdData[0] |=> rspValid && rspFault);
endmodule

// File: tb/page_walker_tb.sv
module page_walker_tb;
  localparam int VA_W = 48;
  localparam int PA_W = 52;

  typedef struct packed {
    logic paging, pae, lng, wp, wr, usr, ex;
    logic [VA_W-1:0] va;
    logic [PA_W-1:0] root;
    logic            expFault;
    logic [PA_W-1:0] expPa;
    logic [2:0]      expReads;
    logic [PA_W-1:0] expFirst;
    logic [3:0]      reqNo;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R13 R2 R3: 32-bit 4 KiB walk
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_0040_3ABC, 52'h1_0000_1018, 1'b0, 52'h5_5ABC, 3'd2, 52'h1004, 4'd13},
    // R8: no-execute ignored with 32-bit entries (bit 63 of returned data set)
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 48'h0000_0040_3ABC, 52'h1_0000_1018, 1'b0, 52'h5_5ABC, 3'd2, 52'h1004, 4'd8},
    // R6: write to read-only with enforcement faults
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 48'h0000_0040_4123, 52'h1_0000_1018, 1'b1, 52'h0,      3'd2, 52'h1004, 4'd6},
    // R6: write to read-only without enforcement passes
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 48'h0000_0040_4123, 52'h1_0000_1018, 1'b0, 52'h6_6123, 3'd2, 52'h1004, 4'd6},
    // R7: user access to supervisor page faults
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 48'h0000_0040_5010, 52'h1_0000_1018, 1'b1, 52'h0,      3'd2, 52'h1004, 4'd7},
    // R7: supervisor access to same page passes
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_0040_5010, 52'h1_0000_1018, 1'b0, 52'h7_7010, 3'd2, 52'h1004, 4'd7},
    // R5: absent last-level entry
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_0040_6000, 52'h1_0000_1018, 1'b1, 52'h0,      3'd2, 52'h1004, 4'd5},
    // R5: absent top-level entry, one read
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_00C0_0000, 52'h1_0000_1018, 1'b1, 52'h0,      3'd1, 52'h100C, 4'd5},
    // R11: 4 MiB page with extended base
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_0080_1234, 52'h1_0000_1018, 1'b0, 52'h5_0C00_1234, 3'd1, 52'h1008, 4'd11},
    // R9 R1: 3-level walk, top entry lacks user/write bits
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 48'h0000_4060_5321, 52'h0_0000_3027, 1'b0, 52'h9_9321, 3'd3, 52'h3028, 4'd9},
    // R8: execute on no-execute page with 64-bit entries faults
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 48'h0000_4060_5321, 52'h0_0000_3027, 1'b1, 52'h0,      3'd3, 52'h3028, 4'd8},
    // R10: 2 MiB page
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 48'h0000_4080_0456, 52'h0_0000_3027, 1'b0, 52'h12_3460_0456, 3'd2, 52'h3028, 4'd10},
    // R1 R3: 4-level long mode walk
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 48'h0080_4020_1ABC, 52'h0_0000_6018, 1'b0, 52'hA_BCDE_FABC, 3'd4, 52'h6008, 4'd1},
    // R4: paging off
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 48'h0000_1234_5678, 52'h0_0000_6018, 1'b0, 52'h1234_5678, 3'd0, 52'h0, 4'd4}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0, reqExec = 1'b0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic            cfgPaging = 1'b0, cfgPae = 1'b0, cfgLong = 1'b0, cfgWp = 1'b0;
  logic [PA_W-1:0] cfgRoot = '0;
  logic            rspReady = 1'b1;
  logic            memRdDone = 1'b0;
  logic [63:0]     memRdData = '0;
  logic            reqReady, memRdValid, rspValid, rspFault, busy;
  logic [PA_W-1:0] memRdAddr, rspPaddr;

  int readCnt = 0;
  logic [PA_W-1:0] firstAddr = '0;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  page_walker #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser), .reqExec(reqExec),
    .cfgPaging(cfgPaging), .cfgPae(cfgPae), .cfgLong(cfgLong), .cfgWp(cfgWp),
    .cfgRoot(cfgRoot), .memRdValid(memRdValid), .memRdAddr(memRdAddr),
    .memRdDone(memRdDone), .memRdData(memRdData), .rspValid(rspValid),
    .rspReady(rspReady), .rspPaddr(rspPaddr), .rspFault(rspFault), .busy(busy)
  );

  function automatic logic [63:0] memLookup(input logic [PA_W-1:0] a);
    case (a)
      52'h1004: return 64'h0000_2007;
      52'h1008: return 64'h0C00_A087;
      52'h200C: return 64'h8000_0000_0005_5007;
      52'h2010: return 64'h0006_6005;
      52'h2014: return 64'h0007_7003;
      52'h3028: return 64'h0000_4001;
      52'h4018: return 64'h0000_5007;
      52'h4020: return 64'h0000_0012_3460_0087;
      52'h5028: return 64'h8000_0000_0009_9007;
      52'h6008: return 64'h0000_7007;
      52'h7008: return 64'h0000_8007;
      52'h8008: return 64'h0000_9007;
      52'h9008: return 64'h0000_000A_BCDE_F007;
      default:  return 64'h0;
    endcase
  endfunction

  // memory model: answers one cycle after a read is seen
  always @(posedge clk) begin
    if (reqValid && reqReady) readCnt <= 0;
    if (memRdValid && !memRdDone) begin
      memRdDone <= 1'b1;
      memRdData <= memLookup(memRdAddr);
    end else begin
      memRdDone <= 1'b0;
    end
    if (memRdValid && memRdDone) begin
      if (readCnt == 0) firstAddr <= memRdAddr;
      readCnt <= readCnt + 1;
    end
  end

  task automatic check(input bit ok, input int reqNo, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", reqNo, what, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    cfgPaging = v.paging; cfgPae = v.pae; cfgLong = v.lng; cfgWp = v.wp;
    cfgRoot = v.root; reqVaddr = v.va;
    reqWrite = v.wr; reqUser = v.usr; reqExec = v.ex; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL R12 watchdog actual=hung expected=response");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(reqReady && !busy && !rspValid && !memRdValid, 12, "reset idle",
          {60'h0, reqReady, busy, rspValid, memRdValid}, 64'h8);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      check(rspFault == VECS[i].expFault, VECS[i].reqNo, "fault",
            64'(rspFault), 64'(VECS[i].expFault));
      if (!VECS[i].expFault)
        check(rspPaddr == VECS[i].expPa, VECS[i].reqNo, "paddr",
              64'(rspPaddr), 64'(VECS[i].expPa));
      check(readCnt == int'(VECS[i].expReads), VECS[i].reqNo, "read count",
            64'(readCnt), 64'(VECS[i].expReads));
      if (VECS[i].expReads != 3'd0)
        check(firstAddr == VECS[i].expFirst, VECS[i].reqNo, "first read addr R2",
              64'(firstAddr), 64'(VECS[i].expFirst));
      @(negedge clk);
    end

    // R12: response held while not accepted, new request refused meanwhile
    rspReady = 1'b0;
    issue(VECS[0]);
    reqVaddr = 48'h0000_0040_5010; reqValid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rspValid && busy && !reqReady, 12, "held response",
            {61'h0, rspValid, busy, reqReady}, 64'h6);
      check(rspPaddr == 52'h5_5ABC, 12, "held paddr", 64'(rspPaddr), 64'h5_5ABC);
    end
    reqValid = 1'b0; rspReady = 1'b1;
    @(negedge clk);
    check(!rspValid && reqReady && !busy, 12, "released",
          {61'h0, rspValid, reqReady, busy}, 64'h2);

    // R6: write to read-only page through the next request after release
    issue(VECS[2]);
    check(rspFault == 1'b1, 6, "fault after release", 64'(rspFault), 64'h1);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule